// File: doc/BRIEF.md
# Postfix Stack Evaluation Engine

This block evaluates postfix (reverse Polish) arithmetic with a small operand stack held in hardware. Instructions carry no register fields. An instruction is an opcode, plus a data-memory address for the two instructions that move words between memory and the stack. Add, subtract and multiply take both of their operands from the top of the stack and leave one result in their place. A sequencer outside the block hands over one instruction at a time on a ready/valid handshake. The engine lowers its ready flag while an instruction still needs cycles, and it pulses a completion flag when each instruction ends. Error flags travel with that pulse when the stack is too empty or too full for the instruction.

The data memory sits outside the block behind a plain synchronous port: one read enable, one write enable, a shared address, write data, and read data that arrives in the cycle after the read is requested. Only the two memory-moving instructions ever drive this port. The stack depth, the word width and the address width are parameters. The default stack holds eight 16-bit words.

Top module: `postfix_stack_engine`

## Requirements
- R1: After a synchronous active-high reset the engine has an empty stack, in_ready is 1, and done, err_under, err_over, mem_rd_en and mem_wr_en are 0.
- R2: Opcode 0 (load) accepted with address A on a non-full stack drives mem_rd_en=1 with mem_addr=A in the next cycle. in_ready is 0 for two cycles. In the third cycle after acceptance, done=1, in_ready=1, and the word returned by memory is the new top of stack.
- R3: Opcode 1 (store) accepted with address A on a non-empty stack removes the top entry and writes it to address A: mem_wr_en=1, mem_addr=A and mem_wdata=top, all in the next cycle together with done. in_ready stays 1.
- R4: Opcode 2 replaces the two topmost entries with their sum modulo 2^16 and completes in one cycle.
- R5: Opcode 3 replaces the two topmost entries with (next-to-top minus top) modulo 2^16.
- R6: Opcode 4 replaces the two topmost entries with the low 16 bits of their product.
- R7: Only opcodes 0 and 1 use the memory port. The number of read cycles equals the number of successful loads, and every write belongs to a successful store.
- R8: An arithmetic opcode issued with fewer than two entries, or a store issued on an empty stack, completes with done=1 and err_under=1. It writes nothing, and it leaves the stack contents and depth unchanged.
- R9: A load issued when the stack holds its full depth of entries completes in one cycle with done=1 and err_over=1. It issues no memory read and leaves the stack unchanged.
- R10: Opcodes 5, 6 and 7 complete in one cycle with done=1, set no error flag, and have no effect on the stack or memory.
- R11: The sequence load X, load Y, mul, load W, load U, mul, add, store Z writes X*Y+W*U to Z and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered this cycle |
| in_ready | output | 1 | Engine can accept an instruction |
| in_op | input | 3 | Opcode: 0 load, 1 store, 2 add, 3 sub, 4 mul |
| in_addr | input | 8 | Memory address for load and store |
| done | output | 1 | One-cycle pulse when an instruction completes |
| err_under | output | 1 | Stack underflow, valid with done |
| err_over | output | 1 | Stack overflow, valid with done |
| mem_rd_en | output | 1 | Data memory read request |
| mem_wr_en | output | 1 | Data memory write request |
| mem_addr | output | 8 | Data memory address |
| mem_wdata | output | 16 | Data memory write data |
| mem_rdata | input | 16 | Data memory read data, one cycle after mem_rd_en |

## Verification
The bench targets subtraction operand order with a mixed expression whose result flips sign when the operands are swapped. It also checks multiply and add results that exceed 16 bits, where a design that kept the wrong bits would store a different word. Underflow and overflow are driven at the exact boundary depths, and the stack is then drained to show that the failed instruction neither moved the pointer nor overwrote an entry. A design that pushed on overflow or popped on underflow would return shifted values. Cycle-exact checks on the load make sure the read data is captured in the cycle it arrives, and not one cycle early or late.

// File: rtl/pse_pkg.sv
package pse_pkg;
  localparam logic [2:0] OPC_LOAD  = 3'd0;
  localparam logic [2:0] OPC_STORE = 3'd1;
  localparam logic [2:0] OPC_ADD   = 3'd2;
  localparam logic [2:0] OPC_SUB   = 3'd3;
  localparam logic [2:0] OPC_MUL   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2
  } eng_state_t;

  function automatic logic is_arith(input logic [2:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_MUL);
  endfunction
endpackage

// File: rtl/pse_stack.sv
module pse_stack #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             do_push,
  input  logic                             do_pop,
  input  logic                             do_fold,
  input  logic [WIDTH-1:0]                 wdata,
  output logic [WIDTH-1:0]                 top,
  output logic [WIDTH-1:0]                 next,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] cells [DEPTH];
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    idx_free, idx_top, idx_next;

  assign idx_free = PW'(cnt);
  assign idx_top  = PW'(cnt - CW'(1));
  assign idx_next = PW'(cnt - CW'(2));

  // Single write port: a push fills the free slot, a fold overwrites next-to-top.
  always_ff @(posedge clk) begin
    if (do_push)
      cells[idx_free] <= wdata;
    else if (do_fold)
      cells[idx_next] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (do_push)
      cnt <= cnt + CW'(1);
    else if (do_pop || do_fold)
      cnt <= cnt - CW'(1);
  end

  assign top   = cells[idx_top];
  assign next  = cells[idx_next];
  assign count = cnt;
endmodule

// File: rtl/pse_alu.sv
module pse_alu #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] result
);
  import pse_pkg::*;

  always_comb begin
    unique case (op)
      OPC_ADD: result = lhs + rhs;
      OPC_SUB: result = lhs - rhs;
      OPC_MUL: result = lhs * rhs;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/postfix_stack_engine.sv
module postfix_stack_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              done,
  output logic              err_under,
  output logic              err_over,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import pse_pkg::*;

  localparam int CW = $clog2(DEPTH+1);

  eng_state_t       state;
  logic             accept, full, empty, has_two;
  logic             do_push, do_pop, do_fold;
  logic [DATA_W-1:0] top_w, next_w, alu_y, push_w;
  logic [CW-1:0]    depth_w;

  assign accept  = in_valid && in_ready && (state == ST_IDLE);
  assign full    = (depth_w == CW'(DEPTH));
  assign empty   = (depth_w == '0);
  assign has_two = (depth_w >= CW'(2));

  assign do_push = (state == ST_CAPT);
  assign do_pop  = accept && (in_op == OPC_STORE) && !empty;
  assign do_fold = accept && is_arith(in_op) && has_two;
  assign push_w  = do_push ? mem_rdata : alu_y;

  pse_stack #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .do_push(do_push),
    .do_pop (do_pop),
    .do_fold(do_fold),
    .wdata  (push_w),
    .top    (top_w),
    .next   (next_w),
    .count  (depth_w)
  );

  pse_alu #(.WIDTH(DATA_W)) u_alu (
    .op    (in_op),
    .lhs   (next_w),
    .rhs   (top_w),
    .result(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      in_ready  <= 1'b1;
      done      <= 1'b0;
      err_under <= 1'b0;
      err_over  <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done      <= 1'b0;
      err_under <= 1'b0;
      err_over  <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (in_op == OPC_LOAD) begin
              if (full) begin
                done     <= 1'b1;
                err_over <= 1'b1;
              end else begin
                mem_rd_en <= 1'b1;
                mem_addr  <= in_addr;
                in_ready  <= 1'b0;
                state     <= ST_READ;
              end
            end else if (in_op == OPC_STORE) begin
              done <= 1'b1;
              if (empty) begin
                err_under <= 1'b1;
              end else begin
                mem_wr_en <= 1'b1;
                mem_addr  <= in_addr;
                mem_wdata <= top_w;
              end
            end else if (is_arith(in_op)) begin
              done      <= 1'b1;
              err_under <= !has_two;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_READ: state <= ST_CAPT;
        ST_CAPT: begin
          state    <= ST_IDLE;
          in_ready <= 1'b1;
          done     <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pse_checker.sv
module pse_checker (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic done,
  input logic err_under,
  input logic err_over,
  input logic mem_rd_en,
  input logic mem_wr_en
);
  AST_LOAD_READS: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> mem_rd_en); // R2
  AST_LOAD_FINISH: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> ##2 (in_ready && done)); // R2
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !in_ready); // R7
  AST_WRITE_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (done && in_ready && !err_under && !err_over)); // R3
  AST_UNDER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err_under |-> (done && !mem_wr_en && !err_over)); // R8
  AST_OVER_NO_READ: assert property (@(posedge clk) disable iff (rst)
    err_over |-> (done && !mem_rd_en && in_ready)); // R9
endmodule

bind postfix_stack_engine pse_checker u_pse_checker (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .done     (done),
  .err_under(err_under),
  .err_over (err_over),
  .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en)
);

// File: tb/postfix_stack_engine_test.sv
`timescale 1ns/1ps
module postfix_stack_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [7:0]  in_addr = 8'd0;
  logic        done, err_under, err_over, mem_rd_en, mem_wr_en;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'd0;

  always #4 clk = ~clk;

  postfix_stack_engine uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .done(done), .err_under(err_under),
    .err_over(err_over), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] ram [256];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
    if (mem_wr_en) ram[mem_addr] <= mem_wdata;
  end

  int checks = 0;
  int errors = 0;
  int rd_seen = 0;
  int rd_exp = 0;
  int cycles = 0;

  // bench-side reference model
  logic [15:0] shadow [256];
  logic [15:0] mstk [8];
  int mcnt = 0;

  logic [1:0]  exp_st  [$];
  string       exp_tag [$];
  logic [23:0] exp_wr  [$];
  string       wr_tag  [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  // monitor / scoreboard
  logic [1:0]  m_st;
  string       m_tag;
  logic [23:0] m_wr;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rd_seen++;
      if (done) begin
        if (exp_st.size() == 0) begin
          check(1'b0, "R10", 32'(done), 32'd0);
        end else begin
          m_st  = exp_st.pop_front();
          m_tag = exp_tag.pop_front();
          check({err_under, err_over} == m_st, m_tag, 32'({err_under, err_over}), 32'(m_st));
        end
      end else begin
        check(!err_under && !err_over, "R8", 32'({err_under, err_over}), 32'd0);
      end
      if (mem_wr_en) begin
        if (exp_wr.size() == 0) begin
          check(1'b0, "R7", {8'd0, mem_addr, mem_wdata}, 32'd0);
        end else begin
          m_wr  = exp_wr.pop_front();
          m_tag = wr_tag.pop_front();
          check({mem_addr, mem_wdata} == m_wr, m_tag, {8'd0, mem_addr, mem_wdata}, {8'd0, m_wr});
        end
      end
    end
  end

  task automatic set_mem(input logic [7:0] a, input logic [15:0] v);
    ram[a] = v;
    shadow[a] = v;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input string tag, input bit timed = 1'b0);
    logic [15:0] x, y, r;
    case (op)
      3'd0: if (mcnt == 8) exp_st.push_back(2'b01);
            else begin mstk[mcnt] = shadow[a]; mcnt++; rd_exp++; exp_st.push_back(2'b00); end
      3'd1: if (mcnt == 0) exp_st.push_back(2'b10);
            else begin
              mcnt--;
              exp_wr.push_back({a, mstk[mcnt]});
              wr_tag.push_back(tag);
              shadow[a] = mstk[mcnt];
              exp_st.push_back(2'b00);
            end
      3'd2, 3'd3, 3'd4:
            if (mcnt < 2) exp_st.push_back(2'b10);
            else begin
              x = mstk[mcnt-2];
              y = mstk[mcnt-1];
              if (op == 3'd2) r = x + y;
              else if (op == 3'd3) r = x - y;
              else r = x * y;
              mstk[mcnt-2] = r;
              mcnt--;
              exp_st.push_back(2'b00);
            end
      default: exp_st.push_back(2'b00);
    endcase
    exp_tag.push_back(tag);

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_addr  = a;
    @(posedge clk);
    #1 in_valid = 1'b0;
    if (timed && op == 3'd0) begin
      @(negedge clk);
      check(mem_rd_en && mem_addr == a && !in_ready, "R2", {mem_rd_en, in_ready, mem_addr}, {2'b10, a});
      @(negedge clk);
      check(!mem_rd_en && !in_ready && !done, "R2", {mem_rd_en, in_ready, done}, 3'b000);
      @(negedge clk);
      check(done && in_ready, "R2", {done, in_ready}, 2'b11);
    end
    if (timed && op == 3'd1) begin
      @(negedge clk);
      check(done && mem_wr_en && in_ready, "R3", {done, mem_wr_en, in_ready}, 3'b111);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'd0;
      shadow[i] = 16'd0;
    end
    repeat (3) @(negedge clk);
    check(in_ready && !done && !err_under && !err_over && !mem_rd_en && !mem_wr_en, "R1",
          {in_ready, done, err_under, err_over, mem_rd_en, mem_wr_en}, 6'b100000);
    rst = 1'b0;

    // R2 / R3: load timing, store timing
    set_mem(8'd10, 16'hBEEF);
    issue(3'd0, 8'd10, "R2", 1'b1);
    issue(3'd1, 8'd20, "R3", 1'b1);

    // R11: X*Y + W*U
    set_mem(8'd1, 16'd3); set_mem(8'd2, 16'd5); set_mem(8'd3, 16'd7); set_mem(8'd4, 16'd2);
    issue(3'd0, 8'd1, "R11"); issue(3'd0, 8'd2, "R11"); issue(3'd4, 8'd0, "R11");
    issue(3'd0, 8'd3, "R11"); issue(3'd0, 8'd4, "R11"); issue(3'd4, 8'd0, "R11");
    issue(3'd2, 8'd0, "R11"); issue(3'd1, 8'd5, "R11");
    issue(3'd1, 8'd6, "R11");  // empty stack: underflow expected

    // R5: (20 - 6) * 4 = 56, then 9 - 2 = 7
    set_mem(8'd30, 16'd20); set_mem(8'd31, 16'd6); set_mem(8'd32, 16'd4);
    issue(3'd0, 8'd30, "R5"); issue(3'd0, 8'd31, "R5"); issue(3'd3, 8'd0, "R5");
    issue(3'd0, 8'd32, "R5"); issue(3'd4, 8'd0, "R5"); issue(3'd1, 8'd33, "R5");
    set_mem(8'd34, 16'd9); set_mem(8'd35, 16'd2);
    issue(3'd0, 8'd34, "R5"); issue(3'd0, 8'd35, "R5"); issue(3'd3, 8'd0, "R5");
    issue(3'd1, 8'd36, "R5");
    // 2 - 9 wraps
    issue(3'd0, 8'd35, "R5"); issue(3'd0, 8'd34, "R5"); issue(3'd3, 8'd0, "R5");
    issue(3'd1, 8'd37, "R5");

    // R6: truncated products
    set_mem(8'd40, 16'h1234); set_mem(8'd41, 16'h0100); set_mem(8'd42, 16'd300);
    issue(3'd0, 8'd40, "R6"); issue(3'd0, 8'd41, "R6"); issue(3'd4, 8'd0, "R6");
    issue(3'd1, 8'd43, "R6");
    issue(3'd0, 8'd42, "R6"); issue(3'd0, 8'd42, "R6"); issue(3'd4, 8'd0, "R6");
    issue(3'd1, 8'd44, "R6");

    // R4: add with wrap
    set_mem(8'd50, 16'hFFFF); set_mem(8'd51, 16'd2);
    issue(3'd0, 8'd50, "R4"); issue(3'd0, 8'd51, "R4"); issue(3'd2, 8'd0, "R4");
    issue(3'd1, 8'd52, "R4");

    // R8: underflow on arithmetic with one entry, stack kept
    set_mem(8'd60, 16'h00A5);
    issue(3'd2, 8'd0, "R8");
    issue(3'd0, 8'd60, "R8");
    issue(3'd3, 8'd0, "R8"); issue(3'd4, 8'd0, "R8");
    issue(3'd1, 8'd61, "R8");

    // R9: fill to full depth, overflow, drain in LIFO order
    for (int i = 0; i < 8; i++) set_mem(8'(70 + i), 16'(16'h0100 + i));
    set_mem(8'd90, 16'hDEAD);
    for (int i = 0; i < 8; i++) issue(3'd0, 8'(70 + i), "R9");
    issue(3'd0, 8'd90, "R9");
    for (int i = 0; i < 8; i++) issue(3'd1, 8'(100 + i), "R9");

    // R10: undefined opcodes leave stack intact
    issue(3'd0, 8'd70, "R10"); issue(3'd0, 8'd71, "R10");
    issue(3'd5, 8'd0, "R10"); issue(3'd6, 8'd0, "R10"); issue(3'd7, 8'd0, "R10");
    issue(3'd1, 8'd110, "R10"); issue(3'd1, 8'd111, "R10");

    repeat (6) @(negedge clk);
    check(exp_st.size() == 0, "R10", 32'(exp_st.size()), 32'd0);
    check(exp_wr.size() == 0, "R3", 32'(exp_wr.size()), 32'd0);
    check(rd_seen == rd_exp, "R7", 32'(rd_seen), 32'(rd_exp));
    check(ram[5] == 16'd29, "R11", 32'(ram[5]), 32'd29);
    finish_run();
  end
endmodule